// File: doc/BRIEF.md
# Hardwired Step Sequencer for a Single-Bus Processor

This block is the control unit of a 32-bit load/store processor whose registers share one internal bus. A four-bit step counter advances through time steps, one per clock. Every gate and strobe of the datapath is an OR of products that combine the current step, the class of the opcode presented by the instruction register, and two datapath flags: the branch condition bit and the zero flag of the shift counter. The outputs are plain combinational functions of the registered step and the opcode input, so they are valid in the same cycle as the step.

Steps 0 to 2 fetch the next instruction and are the same for every opcode. From step 3 on, the opcode picks the sequence. Four control outputs steer the counter itself: the memory-wait strobe holds the step until memory reports completion, the end strobe sends the counter back to step 0, the loop strobe reloads step 6 so that a shift step can repeat, and a synchronous clear input forces step 0 at any time. An asynchronous active-low reset also puts the counter at step 0.

Top module: `ctl_seq`

## Requirements
- R1: `ctl_o` carries one strobe per bit: 0 pc_out, 1 ma_in, 2 inc4, 3 c_in, 4 mem_rd, 5 c_out, 6 pc_in, 7 mem_wait, 8 md_out, 9 ir_in, 10 sel_a, 11 sel_b, 12 sel_c, 13 reg_out, 14 reg_in, 15 base_out, 16 a_in, 17 alu_add, 18 c2_out, 19 md_in, 20 mem_wr, 21 end, 22 c1_out, 23 cnt_ld, 24 pass_b, 25 alu_shr, 26 cnt_dec, 27 loop6, 28 con_in. Whatever the opcode, step 0 asserts exactly {pc_out, ma_in, inc4, c_in, mem_rd}, step 1 exactly {c_out, pc_in, mem_wait}, and step 2 exactly {md_out, ir_in}.
- R2: While mem_wait is asserted and `mem_done_i` is low, the step does not change.
- R3: When end is asserted and the step is not stalled, the next step is 0.
- R4: `rst_n` low puts the step at 0 at once; `clr_i` high makes the next step 0 whatever else is asserted.
- R5: With no stall, no end, no loop6 and no clear, the step increases by one each clock.
- R6: For opcode 12 (add), steps 3, 4, 5 assert exactly {sel_b, reg_out, a_in}, {sel_c, reg_out, alu_add, c_in}, {c_out, sel_a, reg_in, end}.
- R7: For opcode 13 (add immediate), steps 3 and 5 match add, and step 4 asserts exactly {c2_out, alu_add, c_in}.
- R8: For opcode 3 (store), steps 3 to 7 assert exactly {sel_b, base_out, a_in}, {c2_out, alu_add, c_in}, {c_out, ma_in}, {sel_a, reg_out, md_in, mem_wr}, {mem_wait, end}.
- R9: For opcode 1 (load), steps 3 to 5 match store, step 6 asserts exactly {mem_rd, mem_wait}, and step 7 exactly {md_out, sel_a, reg_in, end}.
- R10: For opcode 8 (branch), step 3 asserts exactly {sel_c, reg_out, con_in}; step 4 asserts {sel_b, reg_out, end} and adds pc_in only when `con_i` is high.
- R11: For opcode 26 (shift right), step 3 asserts {c1_out, cnt_ld}; step 4 asserts {sel_c, reg_out, cnt_ld} only when `cnt_zero_i` is high and nothing otherwise; step 5 asserts {sel_b, reg_out, pass_b, c_in}; step 6 asserts {c_out, alu_shr, c_in, cnt_dec, loop6} and stays at step 6 while `cnt_zero_i` is low, and asserts nothing and moves to step 7 once it is high; step 7 asserts {c_out, sel_a, reg_in, end}.
- R12: Any other opcode asserts only end at step 3, so the next step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous return to step 0 |
| op_i | input | 5 | Opcode field of the instruction register |
| con_i | input | 1 | Branch condition bit from the datapath |
| cnt_zero_i | input | 1 | Shift counter equals zero |
| mem_done_i | input | 1 | Memory has completed the current access |
| ctl_o | output | 29 | Gate and strobe vector, bit map in R1 |
| step_o | output | 4 | Current time step |

## Verification
The hardest case to reach is the repeated shift step: the counter must sit at step 6 for exactly as many cycles as the shift count, with the loop strobe and the zero flag meeting at the boundary, and the zero flag must also steer step 4 differently for an immediate count of zero. The bench keeps its own model of the shift counter, loading it when the sequencer asserts cnt_ld and decrementing it on cnt_dec, and drives `cnt_zero_i` from that model, so both a multi-pass loop and a zero-count shift are walked step by step. Memory stalls are raised by holding `mem_done_i` low during step 1 of a fetch and during the final step of a store, where wait and end share one step.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int CW = 29;

  localparam int B_PCO  = 0;
  localparam int B_MAI  = 1;
  localparam int B_INC4 = 2;
  localparam int B_CIN  = 3;
  localparam int B_RD   = 4;
  localparam int B_COUT = 5;
  localparam int B_PCI  = 6;
  localparam int B_WAIT = 7;
  localparam int B_MDO  = 8;
  localparam int B_IRI  = 9;
  localparam int B_SELA = 10;
  localparam int B_SELB = 11;
  localparam int B_SELC = 12;
  localparam int B_ROUT = 13;
  localparam int B_RIN  = 14;
  localparam int B_BAO  = 15;
  localparam int B_AIN  = 16;
  localparam int B_ADD  = 17;
  localparam int B_C2O  = 18;
  localparam int B_MDI  = 19;
  localparam int B_WR   = 20;
  localparam int B_END  = 21;
  localparam int B_C1O  = 22;
  localparam int B_LD   = 23;
  localparam int B_PASS = 24;
  localparam int B_SHR  = 25;
  localparam int B_DEC  = 26;
  localparam int B_LOOP = 27;
  localparam int B_CONI = 28;

  localparam logic [4:0] OPC_LOAD  = 5'd1;
  localparam logic [4:0] OPC_STORE = 5'd3;
  localparam logic [4:0] OPC_BRAN  = 5'd8;
  localparam logic [4:0] OPC_ADD   = 5'd12;
  localparam logic [4:0] OPC_ADDI  = 5'd13;
  localparam logic [4:0] OPC_SHR   = 5'd26;

  typedef struct packed {
    logic ld;
    logic st;
    logic br;
    logic add;
    logic addi;
    logic shr;
    logic bad;
  } opcls_t;

endpackage

// File: rtl/ctl_opdec.sv
module ctl_opdec
  import ctl_pkg::*;
#(
  parameter int OW = 5
) (
  input  logic [OW-1:0] op_i,
  output opcls_t        cls_o
);

  always_comb begin
    cls_o = '0;
    case (op_i)
      OW'(OPC_LOAD):  cls_o.ld   = 1'b1;
      OW'(OPC_STORE): cls_o.st   = 1'b1;
      OW'(OPC_BRAN):  cls_o.br   = 1'b1;
      OW'(OPC_ADD):   cls_o.add  = 1'b1;
      OW'(OPC_ADDI):  cls_o.addi = 1'b1;
      OW'(OPC_SHR):   cls_o.shr  = 1'b1;
      default:        cls_o.bad  = 1'b1;
    endcase
  end

  always_comb begin
    a_r12_onehot_class: assert ($onehot(cls_o)) else $error("opcode class not one-hot");
  end

endmodule

// File: rtl/ctl_stepctr.sv
module ctl_stepctr #(
  parameter int SW        = 4,
  parameter int LOOP_STEP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          stall_i,
  input  logic          end_i,
  input  logic          loop_i,
  output logic [SW-1:0] step_o
);

  localparam logic [SW-1:0] LOOP_V = SW'(LOOP_STEP);

  logic [SW-1:0] step_q;
  logic [SW-1:0] step_d;
  logic          step_en;

  assign step_en = clr_i | ~stall_i;

  always_comb begin
    if (clr_i)       step_d = '0;
    else if (end_i)  step_d = '0;
    else if (loop_i) step_d = LOOP_V;
    else             step_d = step_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign step_o = step_q;

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !clr_i) |=> $stable(step_q));

  a_r3_end_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !stall_i && !clr_i) |=> (step_q == '0));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (step_q == '0));

  a_r11_loop_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_i && !end_i && !stall_i && !clr_i) |=> (step_q == LOOP_V));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_i && !end_i && !stall_i && !clr_i) |=> (step_q == $past(step_q) + SW'(1)));

endmodule

// File: rtl/ctl_encode.sv
module ctl_encode
  import ctl_pkg::*;
#(
  parameter int SW = 4,
  parameter int NT = 8
) (
  input  logic [SW-1:0] step_i,
  input  opcls_t        cls_i,
  input  logic          con_i,
  input  logic          zero_i,
  output logic [CW-1:0] ctl_o
);

  logic [NT-1:0] t;

  for (genvar i = 0; i < NT; i++) begin : g_step
    assign t[i] = (step_i == SW'(i));
  end

  logic alu3, addx, mem2, shloop;

  assign alu3   = cls_i.add | cls_i.addi | cls_i.ld | cls_i.st;
  assign addx   = cls_i.add | cls_i.addi;
  assign mem2   = cls_i.ld | cls_i.st;
  assign shloop = t[6] & cls_i.shr & ~zero_i;

  always_comb begin
    ctl_o         = '0;
    ctl_o[B_PCO]  = t[0];
    ctl_o[B_MAI]  = t[0] | (t[5] & mem2);
    ctl_o[B_INC4] = t[0];
    ctl_o[B_CIN]  = t[0] | (t[4] & alu3) | (t[5] & cls_i.shr) | shloop;
    ctl_o[B_RD]   = t[0] | (t[6] & cls_i.ld);
    ctl_o[B_COUT] = t[1] | (t[5] & alu3) | shloop | (t[7] & cls_i.shr);
    ctl_o[B_PCI]  = t[1] | (t[4] & cls_i.br & con_i);
    ctl_o[B_WAIT] = t[1] | (t[6] & cls_i.ld) | (t[7] & cls_i.st);
    ctl_o[B_MDO]  = t[2] | (t[7] & cls_i.ld);
    ctl_o[B_IRI]  = t[2];
    ctl_o[B_SELA] = (t[5] & addx) | (t[6] & cls_i.st) | (t[7] & (cls_i.ld | cls_i.shr));
    ctl_o[B_SELB] = (t[3] & alu3) | (t[4] & cls_i.br) | (t[5] & cls_i.shr);
    ctl_o[B_SELC] = (t[4] & cls_i.add) | (t[3] & cls_i.br) | (t[4] & cls_i.shr & zero_i);
    ctl_o[B_ROUT] = (t[3] & addx) | (t[4] & cls_i.add) | (t[6] & cls_i.st)
                  | ((t[3] | t[4]) & cls_i.br) | (t[4] & cls_i.shr & zero_i)
                  | (t[5] & cls_i.shr);
    ctl_o[B_RIN]  = (t[5] & addx) | (t[7] & (cls_i.ld | cls_i.shr));
    ctl_o[B_BAO]  = t[3] & mem2;
    ctl_o[B_AIN]  = t[3] & alu3;
    ctl_o[B_ADD]  = t[4] & alu3;
    ctl_o[B_C2O]  = t[4] & (cls_i.addi | mem2);
    ctl_o[B_MDI]  = t[6] & cls_i.st;
    ctl_o[B_WR]   = t[6] & cls_i.st;
    ctl_o[B_END]  = (t[5] & addx) | (t[7] & (mem2 | cls_i.shr))
                  | (t[4] & cls_i.br) | (t[3] & cls_i.bad);
    ctl_o[B_C1O]  = t[3] & cls_i.shr;
    ctl_o[B_LD]   = (t[3] & cls_i.shr) | (t[4] & cls_i.shr & zero_i);
    ctl_o[B_PASS] = t[5] & cls_i.shr;
    ctl_o[B_SHR]  = shloop;
    ctl_o[B_DEC]  = shloop;
    ctl_o[B_LOOP] = shloop;
    ctl_o[B_CONI] = t[3] & cls_i.br;
  end

  always_comb begin
    a_r8_write_only_store: assert (!ctl_o[B_WR] || cls_i.st) else $error("write outside store");
    a_r9_rd_wr_exclusive: assert (!(ctl_o[B_RD] && ctl_o[B_WR])) else $error("read and write together");
    a_r11_loop_not_end: assert (!(ctl_o[B_LOOP] && ctl_o[B_END])) else $error("loop and end together");
  end

endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_pkg::*;
#(
  parameter int SW        = 4,
  parameter int OW        = 5,
  parameter int LOOP_STEP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [OW-1:0] op_i,
  input  logic          con_i,
  input  logic          cnt_zero_i,
  input  logic          mem_done_i,
  output logic [CW-1:0] ctl_o,
  output logic [SW-1:0] step_o
);

  localparam int NT = LOOP_STEP + 2;

  opcls_t        cls;
  logic [SW-1:0] step;
  logic [CW-1:0] ctl;
  logic          stall;

  assign stall = ctl[B_WAIT] & ~mem_done_i;

  ctl_opdec #(.OW(OW)) u_dec (
    .op_i  (op_i),
    .cls_o (cls)
  );

  ctl_stepctr #(.SW(SW), .LOOP_STEP(LOOP_STEP)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .stall_i (stall),
    .end_i   (ctl[B_END]),
    .loop_i  (ctl[B_LOOP]),
    .step_o  (step)
  );

  ctl_encode #(.SW(SW), .NT(NT)) u_enc (
    .step_i (step),
    .cls_i  (cls),
    .con_i  (con_i),
    .zero_i (cnt_zero_i),
    .ctl_o  (ctl)
  );

  assign ctl_o  = ctl;
  assign step_o = step;

  a_r10_pcin_needs_con: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o[B_PCI] && step_o != SW'(1)) |-> con_i);

endmodule

// File: tb/sim_ctl_seq.sv
module sim_ctl_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i;
  logic [4:0]  op_i;
  logic        con_i;
  logic        cnt_zero_i;
  logic        mem_done_i;
  logic [28:0] ctl_o;
  logic [3:0]  step_o;

  int checks = 0;
  int errors = 0;

  localparam logic [28:0] PCO  = 29'd1 << 0;
  localparam logic [28:0] MAI  = 29'd1 << 1;
  localparam logic [28:0] INC4 = 29'd1 << 2;
  localparam logic [28:0] CIN  = 29'd1 << 3;
  localparam logic [28:0] RD   = 29'd1 << 4;
  localparam logic [28:0] COUT = 29'd1 << 5;
  localparam logic [28:0] PCI  = 29'd1 << 6;
  localparam logic [28:0] WT   = 29'd1 << 7;
  localparam logic [28:0] MDO  = 29'd1 << 8;
  localparam logic [28:0] IRI  = 29'd1 << 9;
  localparam logic [28:0] SA   = 29'd1 << 10;
  localparam logic [28:0] SB   = 29'd1 << 11;
  localparam logic [28:0] SC   = 29'd1 << 12;
  localparam logic [28:0] ROUT = 29'd1 << 13;
  localparam logic [28:0] RIN  = 29'd1 << 14;
  localparam logic [28:0] BAO  = 29'd1 << 15;
  localparam logic [28:0] AIN  = 29'd1 << 16;
  localparam logic [28:0] ADD  = 29'd1 << 17;
  localparam logic [28:0] C2O  = 29'd1 << 18;
  localparam logic [28:0] MDI  = 29'd1 << 19;
  localparam logic [28:0] WR   = 29'd1 << 20;
  localparam logic [28:0] ENDS = 29'd1 << 21;
  localparam logic [28:0] C1O  = 29'd1 << 22;
  localparam logic [28:0] LDN  = 29'd1 << 23;
  localparam logic [28:0] PASS = 29'd1 << 24;
  localparam logic [28:0] SHR  = 29'd1 << 25;
  localparam logic [28:0] DEC  = 29'd1 << 26;
  localparam logic [28:0] LOOP = 29'd1 << 27;
  localparam logic [28:0] CONI = 29'd1 << 28;

  localparam logic [28:0] F0 = PCO | MAI | INC4 | CIN | RD;
  localparam logic [28:0] F1 = COUT | PCI | WT;
  localparam logic [28:0] F2 = MDO | IRI;

  ctl_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .op_i       (op_i),
    .con_i      (con_i),
    .cnt_zero_i (cnt_zero_i),
    .mem_done_i (mem_done_i),
    .ctl_o      (ctl_o),
    .step_o     (step_o)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_at(input string req, input logic [3:0] s, input logic [28:0] v);
    #1;
    checks++;
    if (step_o !== s || ctl_o !== v) begin
      errors++;
      $display("FAIL %s: step=%0d ctl=%h, expected step=%0d ctl=%h", req, step_o, ctl_o, s, v);
    end
  endtask

  task automatic fetch(input logic [4:0] op, input int stalls);
    op_i = op;
    mem_done_i = 1'b1;
    expect_at("R1", 4'd0, F0); tick();
    mem_done_i = (stalls == 0);
    for (int k = 0; k < stalls; k++) begin
      expect_at("R2", 4'd1, F1); tick();
    end
    mem_done_i = 1'b1;
    expect_at("R1", 4'd1, F1); tick();
    expect_at("R1", 4'd2, F2); tick();
  endtask

  task automatic t_add();
    fetch(5'd12, 2);
    expect_at("R6", 4'd3, SB | ROUT | AIN); tick();
    expect_at("R6", 4'd4, SC | ROUT | ADD | CIN); tick();
    expect_at("R6", 4'd5, COUT | SA | RIN | ENDS); tick();
    expect_at("R3", 4'd0, F0);
  endtask

  task automatic t_addi();
    fetch(5'd13, 0);
    expect_at("R7", 4'd3, SB | ROUT | AIN); tick();
    expect_at("R7", 4'd4, C2O | ADD | CIN); tick();
    expect_at("R7", 4'd5, COUT | SA | RIN | ENDS); tick();
    expect_at("R5", 4'd0, F0);
  endtask

  task automatic t_store();
    fetch(5'd3, 1);
    expect_at("R8", 4'd3, SB | BAO | AIN); tick();
    expect_at("R8", 4'd4, C2O | ADD | CIN); tick();
    expect_at("R8", 4'd5, COUT | MAI); tick();
    expect_at("R8", 4'd6, SA | ROUT | MDI | WR); tick();
    mem_done_i = 1'b0;
    expect_at("R8", 4'd7, WT | ENDS); tick();
    expect_at("R2", 4'd7, WT | ENDS); tick();
    mem_done_i = 1'b1;
    expect_at("R3", 4'd7, WT | ENDS); tick();
    expect_at("R3", 4'd0, F0);
  endtask

  task automatic t_load();
    fetch(5'd1, 0);
    expect_at("R9", 4'd3, SB | BAO | AIN); tick();
    expect_at("R9", 4'd4, C2O | ADD | CIN); tick();
    expect_at("R9", 4'd5, COUT | MAI); tick();
    mem_done_i = 1'b0;
    expect_at("R9", 4'd6, RD | WT); tick();
    mem_done_i = 1'b1;
    expect_at("R2", 4'd6, RD | WT); tick();
    expect_at("R9", 4'd7, MDO | SA | RIN | ENDS); tick();
    expect_at("R3", 4'd0, F0);
  endtask

  task automatic t_branch(input logic c);
    fetch(5'd8, 0);
    con_i = c;
    expect_at("R10", 4'd3, SC | ROUT | CONI); tick();
    expect_at("R10", 4'd4, SB | ROUT | ENDS | (c ? PCI : 29'd0)); tick();
    expect_at("R3", 4'd0, F0);
    con_i = 1'b0;
  endtask

  task automatic t_shift(input int imm, input int reg_cnt);
    int cnt;
    cnt = 0;
    fetch(5'd26, 0);
    cnt_zero_i = 1'b0;
    expect_at("R11", 4'd3, C1O | LDN); tick();
    cnt = imm;
    cnt_zero_i = (cnt == 0);
    if (cnt == 0) begin
      expect_at("R11", 4'd4, SC | ROUT | LDN); tick();
      cnt = reg_cnt;
    end else begin
      expect_at("R11", 4'd4, 29'd0); tick();
    end
    cnt_zero_i = (cnt == 0);
    expect_at("R11", 4'd5, SB | ROUT | PASS | CIN); tick();
    while (cnt != 0) begin
      expect_at("R11", 4'd6, COUT | SHR | CIN | DEC | LOOP); tick();
      cnt--;
      cnt_zero_i = (cnt == 0);
    end
    expect_at("R11", 4'd6, 29'd0); tick();
    expect_at("R11", 4'd7, COUT | SA | RIN | ENDS); tick();
    expect_at("R3", 4'd0, F0);
    cnt_zero_i = 1'b0;
  endtask

  task automatic t_unknown(input logic [4:0] op);
    fetch(op, 0);
    expect_at("R12", 4'd3, ENDS); tick();
    expect_at("R12", 4'd0, F0);
  endtask

  task automatic t_clear();
    fetch(5'd12, 0);
    expect_at("R6", 4'd3, SB | ROUT | AIN);
    clr_i = 1'b1; tick();
    clr_i = 1'b0;
    expect_at("R4", 4'd0, F0);
    fetch(5'd3, 0);
    tick(); tick(); tick();
    mem_done_i = 1'b0;
    expect_at("R8", 4'd6, SA | ROUT | MDI | WR); tick();
    expect_at("R8", 4'd7, WT | ENDS);
    clr_i = 1'b1; tick();
    clr_i = 1'b0;
    mem_done_i = 1'b1;
    expect_at("R4", 4'd0, F0);
  endtask

  task automatic t_async_reset();
    fetch(5'd13, 0);
    #3 rst_n = 1'b0;
    expect_at("R4", 4'd0, F0);
    @(negedge clk);
    rst_n = 1'b1;
    expect_at("R4", 4'd0, F0);
  endtask

  initial begin
    rst_n = 1'b0;
    clr_i = 1'b0;
    op_i = 5'd0;
    con_i = 1'b0;
    cnt_zero_i = 1'b0;
    mem_done_i = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
    expect_at("R4", 4'd0, F0);
    t_add();
    t_addi();
    t_store();
    t_load();
    t_branch(1'b0);
    t_branch(1'b1);
    t_shift(3, 0);
    t_shift(0, 2);
    t_shift(0, 0);
    t_unknown(5'd0);
    t_unknown(5'd31);
    t_clear();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule